// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block finds a divider setting for a PLL. It takes a reference frequency and a requested output frequency. It then tries every allowed combination of reference divider, feedback divider and the two post-dividers, one candidate per clock cycle. A candidate pair of reference and feedback dividers is dropped at once when the VCO frequency it produces falls outside the allowed window. Among the candidates that remain, the engine keeps the one whose output comes closest to the request from below, and it never keeps one that overshoots.

Software or a sequencer starts a search with a single-cycle start pulse. The engine raises busy while it searches. At the end it pulses done for one cycle and presents the result: a packed 24-bit control word, the output frequency actually reached, and a failure flag. The search ends early on the first candidate that hits the target exactly. All divider limits and frequency bounds are parameters, so a small configuration can be swept in full.

Top module: `pll_div_search`

## Requirements
- R1: Before the search, the requested frequency is clamped to the range [FOUT_MIN_HZ, FOUT_MAX_HZ]. The clamped value is the target.
- R2: A (refdiv, fbdiv) pair is rejected when floor(ref*fbdiv/refdiv) lies outside [VCO_MIN_HZ, VCO_MAX_HZ], bounds inclusive. A rejected pair costs exactly one cycle.
- R3: A candidate's output is floor(ref*fbdiv / (refdiv*(pd1+1)*(pd2+1))). The returned rate equals this value for the returned setting.
- R4: A candidate whose output exceeds the target is never chosen. A rate of zero is never chosen.
- R5: The walk order is fbdiv outermost, then refdiv, then pd2, then pd1 innermost, each running from its minimum to its maximum. A candidate replaces the best so far only if its output is strictly higher, so among equal outputs the first one in walk order wins.
- R6: The search stops after the cycle that evaluates the first exact match. Otherwise it stops after the last candidate. A search that evaluates n cycles raises done n cycles after the edge that accepts start.
- R7: The control word holds fbdiv in bits [11:0], refdiv in [17:12], pd1 in [20:18] and pd2 in [23:21]. Every field of a successful result lies within its configured range.
- R8: A start pulse in idle latches the reference and the target and raises busy on the next edge. Start is ignored while busy. Done is high for exactly one cycle, and busy is low in that cycle.
- R9: When no candidate qualifies, fail is 1 and both the control word and the rate are 0. Otherwise fail is 0.
- R10: After reset, busy, done and fail are 0, and the control word and the rate are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle search request, taken only when idle |
| ref_hz_i | input | 64 | Reference frequency in Hz |
| req_hz_i | input | 64 | Requested output frequency in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| fail_o | output | 1 | No qualifying candidate was found |
| ctrl_word_o | output | 24 | Packed divider setting |
| rate_hz_o | output | 64 | Output frequency of the returned setting |

## Verification
The assertions assume three things about the inputs:
- the reference and the requested frequency are held stable only through the start cycle, since they are latched there;
- the configured minimum reference divider is at least one;
- the product of the reference and the largest feedback divider fits in 76 bits.

The bench keeps within these limits. It uses a small divider configuration and reference frequencies in the low hundreds of Hz. It changes the request freely while the engine is busy in order to exercise the rule that start is ignored during a search. A model in the bench walks the same nested order with plain integer division and predicts the control word, the rate, the fail flag and the exact cycle count. The bench runs this model over a sweep of targets for several references, including one reference that can never reach the VCO window.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int FB_W   = 12;
  localparam int RD_W   = 6;
  localparam int PD_W   = 3;
  localparam int CW_W   = FB_W + RD_W + 2 * PD_W;
  localparam int NUM_W  = 64 + FB_W;
  localparam int DEN_W  = RD_W + 2 * (PD_W + 1);

  // Packed MSB-first: pd2 [23:21], pd1 [20:18], refdiv [17:12], fbdiv [11:0]
  typedef struct packed {
    logic [PD_W-1:0] pd2;
    logic [PD_W-1:0] pd1;
    logic [RD_W-1:0] rd;
    logic [FB_W-1:0] fb;
  } pll_setting_t;

  function automatic logic [NUM_W-1:0] udiv(input logic [NUM_W-1:0] num,
                                            input logic [DEN_W-1:0] den);
    logic [DEN_W:0]     rem;
    logic [NUM_W-1:0]   quo;
    rem = '0;
    quo = '0;
    for (int i = NUM_W - 1; i >= 0; i--) begin
      rem = {rem[DEN_W-1:0], num[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
    return quo;
  endfunction
endpackage

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
  import pll_search_pkg::*;
#(
  parameter logic [63:0] VCO_MIN_HZ = 64'd1600000000,
  parameter logic [63:0] VCO_MAX_HZ = 64'd3200000000
) (
  input  logic [63:0]  ref_hz_i,
  input  logic [63:0]  tgt_hz_i,
  input  logic [63:0]  best_hz_i,
  input  pll_setting_t cand_i,
  output logic         vco_ok_o,
  output logic [63:0]  rate_hz_o,
  output logic         take_o,
  output logic         exact_o
);
  localparam logic [NUM_W-1:0] VLO = NUM_W'(VCO_MIN_HZ);
  localparam logic [NUM_W-1:0] VHI = NUM_W'(VCO_MAX_HZ) + NUM_W'(1);

  logic [NUM_W-1:0] num, quo;
  logic [DEN_W-1:0] den;

  always_comb begin
    num = NUM_W'(ref_hz_i) * NUM_W'(cand_i.fb);
    den = DEN_W'(cand_i.rd) * (DEN_W'(cand_i.pd1) + DEN_W'(1))
                            * (DEN_W'(cand_i.pd2) + DEN_W'(1));
    // window check by cross-multiplication: floor(num/rd) in [lo, hi]
    vco_ok_o  = (num >= VLO * NUM_W'(cand_i.rd)) && (num < VHI * NUM_W'(cand_i.rd));
    quo       = udiv(num, den);
    rate_hz_o = (|quo[NUM_W-1:64]) ? '1 : quo[63:0];
    take_o    = vco_ok_o && (rate_hz_o <= tgt_hz_i) && (rate_hz_o > best_hz_i);
    exact_o   = take_o && (rate_hz_o == tgt_hz_i);
  end
endmodule

// File: rtl/pll_search_walker.sv
module pll_search_walker
  import pll_search_pkg::*;
#(
  parameter int FB_MIN = 8,
  parameter int FB_MAX = 1066,
  parameter int RD_MIN = 1,
  parameter int RD_MAX = 63,
  parameter int PD_MAX = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         skip_i,
  output pll_setting_t cand_o,
  output logic         last_pair_o,
  output logic         last_cand_o
);
  localparam logic [FB_W-1:0] FB_LO = FB_W'(FB_MIN);
  localparam logic [FB_W-1:0] FB_HI = FB_W'(FB_MAX);
  localparam logic [RD_W-1:0] RD_LO = RD_W'(RD_MIN);
  localparam logic [RD_W-1:0] RD_HI = RD_W'(RD_MAX);
  localparam logic [PD_W-1:0] PD_HI = PD_W'(PD_MAX);

  pll_setting_t cur_q;
  logic pd_wrap, next_pair;

  assign pd_wrap     = (cur_q.pd1 == PD_HI) && (cur_q.pd2 == PD_HI);
  assign next_pair   = skip_i || (step_i && pd_wrap);
  assign last_pair_o = (cur_q.fb == FB_HI) && (cur_q.rd == RD_HI);
  assign last_cand_o = last_pair_o && pd_wrap;
  assign cand_o      = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{pd2: '0, pd1: '0, rd: RD_LO, fb: FB_LO};
    end else if (clr_i) begin
      cur_q <= '{pd2: '0, pd1: '0, rd: RD_LO, fb: FB_LO};
    end else if (next_pair) begin
      cur_q.pd1 <= '0;
      cur_q.pd2 <= '0;
      if (cur_q.rd == RD_HI) begin
        cur_q.rd <= RD_LO;
        cur_q.fb <= cur_q.fb + 1'b1;
      end else begin
        cur_q.rd <= cur_q.rd + 1'b1;
      end
    end else if (step_i) begin
      if (cur_q.pd1 == PD_HI) begin
        cur_q.pd1 <= '0;
        cur_q.pd2 <= cur_q.pd2 + 1'b1;
      end else begin
        cur_q.pd1 <= cur_q.pd1 + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_best_keeper.sv
module pll_best_keeper
  import pll_search_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         take_i,
  input  pll_setting_t cand_i,
  input  logic [63:0]  rate_i,
  output pll_setting_t best_o,
  output logic [63:0]  best_rate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_o      <= '0;
      best_rate_o <= '0;
    end else if (clr_i) begin
      best_o      <= '0;
      best_rate_o <= '0;
    end else if (take_i) begin
      best_o      <= cand_i;
      best_rate_o <= rate_i;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int          FB_MIN      = 8,
  parameter int          FB_MAX      = 1066,
  parameter int          RD_MIN      = 1,
  parameter int          RD_MAX      = 63,
  parameter int          PD_MAX      = 7,
  parameter logic [63:0] VCO_MIN_HZ  = 64'd1600000000,
  parameter logic [63:0] VCO_MAX_HZ  = 64'd3200000000,
  parameter logic [63:0] FOUT_MIN_HZ = 64'd25000,
  parameter logic [63:0] FOUT_MAX_HZ = 64'd3200000000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [63:0]     ref_hz_i,
  input  logic [63:0]     req_hz_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [CW_W-1:0] ctrl_word_o,
  output logic [63:0]     rate_hz_o
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e       state_q;
  logic [63:0]  ref_q, tgt_q;
  pll_setting_t cand, best;
  logic [63:0]  cand_rate, best_rate;
  logic         vco_ok, take, exact, last_pair, last_cand;
  logic         run, launch, finish;

  function automatic logic [63:0] clamp_req(input logic [63:0] r);
    if (r < FOUT_MIN_HZ)      return FOUT_MIN_HZ;
    else if (r > FOUT_MAX_HZ) return FOUT_MAX_HZ;
    else                      return r;
  endfunction

  assign run    = (state_q == S_RUN);
  assign launch = (state_q == S_IDLE) && start_i;
  assign finish = run && (exact || (vco_ok ? last_cand : last_pair));
  assign busy_o = run;

  pll_search_walker #(
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX), .PD_MAX(PD_MAX)
  ) u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (launch),
    .step_i     (run && vco_ok),
    .skip_i     (run && !vco_ok),
    .cand_o     (cand),
    .last_pair_o(last_pair),
    .last_cand_o(last_cand)
  );

  pll_cand_eval #(
    .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ)
  ) u_eval (
    .ref_hz_i (ref_q),
    .tgt_hz_i (tgt_q),
    .best_hz_i(best_rate),
    .cand_i   (cand),
    .vco_ok_o (vco_ok),
    .rate_hz_o(cand_rate),
    .take_o   (take),
    .exact_o  (exact)
  );

  pll_best_keeper u_keeper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (launch),
    .take_i     (run && take),
    .cand_i     (cand),
    .rate_i     (cand_rate),
    .best_o     (best),
    .best_rate_o(best_rate)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ref_q       <= '0;
      tgt_q       <= '0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      ctrl_word_o <= '0;
      rate_hz_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (launch) begin
        state_q <= S_RUN;
        ref_q   <= ref_hz_i;
        tgt_q   <= clamp_req(req_hz_i);
      end else if (finish) begin
        state_q <= S_IDLE;
        done_o  <= 1'b1;
        // last cycle's candidate may still win
        if (take) begin
          fail_o      <= 1'b0;
          ctrl_word_o <= cand;
          rate_hz_o   <= cand_rate;
        end else if (best_rate != '0) begin
          fail_o      <= 1'b0;
          ctrl_word_o <= best;
          rate_hz_o   <= best_rate;
        end else begin
          fail_o      <= 1'b1;
          ctrl_word_o <= '0;
          rate_hz_o   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
  import pll_search_pkg::*;
#(
  parameter int          FB_MIN      = 8,
  parameter int          FB_MAX      = 1066,
  parameter int          RD_MIN      = 1,
  parameter int          RD_MAX      = 63,
  parameter int          PD_MAX      = 7,
  parameter logic [63:0] FOUT_MIN_HZ = 64'd25000,
  parameter logic [63:0] FOUT_MAX_HZ = 64'd3200000000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            fail_o,
  input logic [CW_W-1:0] ctrl_word_o,
  input logic [63:0]     rate_hz_o,
  input logic [63:0]     tgt_i,
  input logic [63:0]     best_rate_i
);
  pll_setting_t res;
  assign res = ctrl_word_o;

  p_tgt_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tgt_i >= FOUT_MIN_HZ) && (tgt_i <= FOUT_MAX_HZ));

  p_rate_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (rate_hz_o <= tgt_i) && (rate_hz_o != '0));

  p_best_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (best_rate_i >= $past(best_rate_i)));

  p_fields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (int'(res.fb) >= FB_MIN) && (int'(res.fb) <= FB_MAX)
                         && (int'(res.rd) >= RD_MIN) && (int'(res.rd) <= RD_MAX)
                         && (int'(res.pd1) <= PD_MAX) && (int'(res.pd2) <= PD_MAX));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  p_tgt_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tgt_i));

  p_fail_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (ctrl_word_o == '0) && (rate_hz_o == '0));
endmodule

bind pll_div_search pll_div_search_chk #(
  .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX), .PD_MAX(PD_MAX),
  .FOUT_MIN_HZ(FOUT_MIN_HZ), .FOUT_MAX_HZ(FOUT_MAX_HZ)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .ctrl_word_o(ctrl_word_o),
  .rate_hz_o  (rate_hz_o),
  .tgt_i      (tgt_q),
  .best_rate_i(best_rate)
);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;
  localparam int CLK_PERIOD = 10;
  localparam int FB_MIN = 8;
  localparam int FB_MAX = 20;
  localparam int RD_MIN = 1;
  localparam int RD_MAX = 3;
  localparam int PD_MAX = 3;
  localparam longint unsigned VMIN = 1000;
  localparam longint unsigned VMAX = 2000;
  localparam longint unsigned FMIN = 5;
  localparam longint unsigned FMAX = 2000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] ref_hz_i = '0;
  logic [63:0] req_hz_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [23:0] ctrl_word_o;
  logic [63:0] rate_hz_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pll_div_search #(
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX), .PD_MAX(PD_MAX),
    .VCO_MIN_HZ(64'(VMIN)), .VCO_MAX_HZ(64'(VMAX)),
    .FOUT_MIN_HZ(64'(FMIN)), .FOUT_MAX_HZ(64'(FMAX))
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .ref_hz_i(ref_hz_i), .req_hz_i(req_hz_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .ctrl_word_o(ctrl_word_o), .rate_hz_o(rate_hz_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: nested walk with plain integer arithmetic
  task automatic model(input longint unsigned rf, input longint unsigned rq,
                       output logic [23:0] w, output longint unsigned rate,
                       output bit fl, output int cyc);
    longint unsigned tgt, best, vco, r;
    int bfb, brd, bp1, bp2;
    bit stop;
    tgt = (rq < FMIN) ? FMIN : ((rq > FMAX) ? FMAX : rq);
    best = 0; cyc = 0; stop = 0; bfb = 0; brd = 0; bp1 = 0; bp2 = 0;
    for (int fb = FB_MIN; fb <= FB_MAX && !stop; fb++) begin
      for (int rd = RD_MIN; rd <= RD_MAX && !stop; rd++) begin
        vco = (rf * longint'(fb)) / longint'(rd);
        if (vco < VMIN || vco > VMAX) begin
          cyc++;
          continue;
        end
        for (int p2 = 0; p2 <= PD_MAX && !stop; p2++) begin
          for (int p1 = 0; p1 <= PD_MAX && !stop; p1++) begin
            cyc++;
            r = (rf * longint'(fb)) / longint'(rd * (p1 + 1) * (p2 + 1));
            if (r <= tgt && r > best) begin
              best = r; bfb = fb; brd = rd; bp1 = p1; bp2 = p2;
              if (r == tgt) stop = 1;
            end
          end
        end
      end
    end
    fl   = (best == 0);
    rate = best;
    w    = fl ? 24'd0 : {3'(bp2), 3'(bp1), 6'(brd), 12'(bfb)};
  endtask

  task automatic search(input longint unsigned rf, input longint unsigned rq,
                        input bit poke_busy);
    logic [23:0] ew;
    longint unsigned er;
    bit ef;
    int ec, cnt;
    model(rf, rq, ew, er, ef, ec);
    @(negedge clk_i);
    ref_hz_i = rf; req_hz_i = rq; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 1;
    chk(busy_o === 1'b1, "R8", "busy after start", 64'(busy_o), 1);
    if (poke_busy) begin
      // new request while busy must be ignored
      ref_hz_i = rf + 7; req_hz_i = rq / 2 + 3; start_i = 1'b1;
      @(negedge clk_i);
      cnt++;
      start_i = 1'b0;
    end
    while (!done_o && cnt < 5000) begin
      @(negedge clk_i);
      cnt++;
    end
    chk(done_o === 1'b1, "R6", "done reached", 64'(done_o), 1);
    chk(cnt == ec + 1, "R6", "latency to done (R2 skip cost)", 64'(cnt), 64'(ec + 1));
    chk(fail_o === ef, "R9", "fail flag", 64'(fail_o), 64'(ef));
    chk(ctrl_word_o === ew, "R5", "control word (R7 layout)", 64'(ctrl_word_o), 64'(ew));
    chk(rate_hz_o === er, "R3", "rate (R4 cap, R1 clamp)", rate_hz_o, er);
    @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R8", "done one cycle", 64'(done_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R10: reset state
    chk(busy_o === 1'b0 && done_o === 1'b0 && fail_o === 1'b0, "R10", "flags in reset",
        64'({busy_o, done_o, fail_o}), 0);
    chk(ctrl_word_o === '0 && rate_hz_o === '0, "R10", "outputs in reset", rate_hz_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10", "idle after reset", 64'(busy_o), 0);

    // R1: clamp boundaries
    search(100, 0, 0);
    search(100, 5000, 0);
    search(100, 2000, 0);
    search(150, 2000, 0);
    // R9: no pair reaches the VCO window
    search(10, 500, 0);
    // R8: start while busy
    search(100, 777, 1);
    search(150, 321, 1);
    // R5, R6: sweeps over targets for several references
    for (int t = 0; t <= 2100; t += 53) search(100, longint'(t), 0);
    for (int t = 3; t <= 2100; t += 53) search(150, longint'(t), 0);
    for (int t = 11; t <= 2100; t += 53) search(73, longint'(t), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule